// File: doc/BRIEF.md
# Single-Data-Rate SDRAM Controller with Auto-Precharge

This block connects a simple single-beat request port to an external single-data-rate SDRAM with a 32-bit data bus. After reset it brings the memory up. It then serves one read or one write at a time. Each access opens a row, touches one column and lets the memory close the row again by itself. There is no page tracking: every access pays the full row-open cost.

A user presents a request with `req_valid`, together with a direction, a flat word address and, for writes, the data. The request is taken on a clock edge where `ready` is high. The flat address is split into three fields:

- column in the low bits;
- bank above the column;
- row in the top bits.

The row and bank go out with the activate command, and the column follows with the read or write command. Read data comes back on `rd_data` with a one-cycle `rd_valid` pulse.

A background interval counter starts once bring-up is complete. When it expires, the controller stops accepting requests. At its next idle moment it issues an auto-refresh, and it never issues one inside an access. All command spacings are parameters counted in controller clock cycles. The defaults are sized for a 27 MHz clock.

Top module: `sdctl_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, `sd_cke` is low. During that time the command pins carry NOP ({cs_n,ras_n,cas_n,we_n}=0111), `ready` and `rd_valid` are low, and the controller does not drive `sd_dq`.
- R2: Bring-up follows a fixed order. First come at least INIT_CYC cycles of NOP with CKE high. Then a precharge with A10=1 (all banks), two auto-refresh commands, and a mode-register load with A[2:0]=000 (one-word burst), A3=0 (sequential) and A[6:4]=CAS_LAT. `ready` stays low until the mode load has been issued.
- R3: Only the following command codes on {cs_n,ras_n,cas_n,we_n} ever appear: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode load 0000.
- R4: A request at `req_addr` produces an activate carrying row=`req_addr[COL_W+BANK_W+:ROW_W]` on A and bank=`req_addr[COL_W+:BANK_W]` on BA. This is followed by one read or write to the same bank with column=`req_addr[COL_W-1:0]` on A and A10=1 (auto-precharge).
- R5: The gap from each command to the next non-NOP command is at least the following number of cycles: T_RP after a precharge, T_RC after an auto-refresh, T_MRD after a mode load, T_RCD after an activate, and T_RECOVER after a read or write.
- R6: The controller drives `sd_dq` only in the cycle in which the write command is on the pins, and there it drives the write data. In every other cycle, including the whole read return window, `sd_dq` is released.
- R7: For a read, the controller samples `sd_dq` CAS_LAT cycles after the memory takes the read command. It raises `rd_valid` for one cycle, CAS_LAT+1 cycles after that command cycle, and `rd_data` then holds the word most recently written to that address.
- R8: After bring-up, an auto-refresh is issued every REF_INT+1 cycles when idle. When an access is in progress, the refresh is delayed by at most T_RCD+T_RECOVER cycles. It is never issued while any row is open.
- R9: `ready` is high only when the controller is idle and no refresh is due. A request is accepted exactly on an edge with `req_valid` and `ready` both high, and the activate follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+BANK_W+COL_W | Flat word address {row, bank, column} |
| req_wdata | input | DATA_W | Write data |
| ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | DATA_W | Returned read data |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_a | output | ROW_W | Multiplexed row/column address |
| sd_dq | inout | DATA_W | Bidirectional memory data |

## Verification
Accesses are exercised through a behavioural memory model that keeps data per bank, row and column. The patterns used are:

- Writes to the lowest and highest addresses. These expose a field that is mis-sliced or truncated.
- Two writes that differ only in bank. Reading both back tells a lost bank field apart from a lost row or column.
- An overwrite followed by a read. This separates a real write from stale data.
- Back-to-back reads, a long idle stretch and a continuous read stream that runs across refresh deadlines. These test refresh placement and command spacing against in-flight accesses.

// File: rtl/sdctl_pkg.sv
package sdctl_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } cmd_t;

    typedef enum logic [3:0] {
        ST_WAIT, ST_PRE, ST_REF_A, ST_REF_B, ST_LMR, ST_IDLE, ST_RD, ST_WR
    } state_t;

    // address bit that selects auto-precharge / all banks
    localparam int AP_BIT = 10;

    // counter reload giving a command-to-command gap of t cycles (minimum 2)
    function automatic int gap_load(input int t);
        return (t > 2) ? t - 2 : 0;
    endfunction

endpackage

// File: rtl/sdctl_wait_timer.sv
module sdctl_wait_timer #(
    parameter int W       = 12,
    parameter int RST_VAL = 2700
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= W'(RST_VAL);
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R5
    reload_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> zero);

endmodule

// File: rtl/sdctl_refresh_timer.sv
module sdctl_refresh_timer #(
    parameter int INTERVAL = 210
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ack,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ack) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else if (en && !pend) begin
            if (cnt == CW'(INTERVAL - 1)) pend <= 1'b1;
            else                          cnt  <= cnt + 1'b1;
        end
    end

    // R8
    ack_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> pend);

    // R8
    pend_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !ack) |=> pend);

endmodule

// File: rtl/sdctl_top.sv
module sdctl_top
    import sdctl_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int BANK_W    = 2,
    parameter int DATA_W    = 32,
    parameter int CAS_LAT   = 2,
    parameter int INIT_CYC  = 2700,
    parameter int REF_INT   = 210,
    parameter int T_RP      = 2,
    parameter int T_RC      = 2,
    parameter int T_RCD     = 2,
    parameter int T_MRD     = 2,
    parameter int T_RECOVER = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            req_valid,
    input  logic                            req_write,
    input  logic [ROW_W+BANK_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]               req_wdata,
    output logic                            ready,
    output logic                            rd_valid,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            sd_cke,
    output logic                            sd_cs_n,
    output logic                            sd_ras_n,
    output logic                            sd_cas_n,
    output logic                            sd_we_n,
    output logic [BANK_W-1:0]               sd_ba,
    output logic [ROW_W-1:0]                sd_a,
    inout  wire  [DATA_W-1:0]               sd_dq
);
    localparam int TW = $clog2(INIT_CYC + 1);
    localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;

    state_t state, nx_state, after_q, nx_after;
    cmd_t   issue, cmd_q;
    logic   ld, tmr_zero, ref_pend, ref_ack, accept, init_done, cke_q, oe_q;
    logic [TW-1:0]        ldv;
    logic [ROW_W-1:0]     a_q;
    logic [BANK_W-1:0]    ba_q, bank_q;
    logic [COL_W-1:0]     col_q;
    logic [DATA_W-1:0]    wdata_q, rdata_q;
    logic [CAS_LAT:0]     rdsh;
    logic                 rdv_q;

    sdctl_wait_timer #(.W(TW), .RST_VAL(INIT_CYC)) u_wait (
        .clk(clk), .rst(rst), .load(ld), .val(ldv), .zero(tmr_zero)
    );

    sdctl_refresh_timer #(.INTERVAL(REF_INT)) u_ref (
        .clk(clk), .rst(rst), .en(init_done), .ack(ref_ack), .pend(ref_pend)
    );

    assign ready = (state == ST_IDLE) && !ref_pend;

    always_comb begin
        nx_state = state;
        nx_after = after_q;
        issue    = CMD_NOP;
        ld       = 1'b0;
        ldv      = '0;
        ref_ack  = 1'b0;
        accept   = 1'b0;
        unique case (state)
            ST_WAIT: if (tmr_zero) nx_state = after_q;
            ST_PRE: begin
                issue = CMD_PRE; ld = 1'b1; ldv = TW'(gap_load(T_RP));
                nx_state = ST_WAIT; nx_after = ST_REF_A;
            end
            ST_REF_A: begin
                issue = CMD_REF; ld = 1'b1; ldv = TW'(gap_load(T_RC));
                nx_state = ST_WAIT; nx_after = ST_REF_B;
            end
            ST_REF_B: begin
                issue = CMD_REF; ld = 1'b1; ldv = TW'(gap_load(T_RC));
                nx_state = ST_WAIT; nx_after = ST_LMR;
            end
            ST_LMR: begin
                issue = CMD_LMR; ld = 1'b1; ldv = TW'(gap_load(T_MRD));
                nx_state = ST_WAIT; nx_after = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    issue = CMD_REF; ref_ack = 1'b1; ld = 1'b1;
                    ldv = TW'(gap_load(T_RC));
                    nx_state = ST_WAIT; nx_after = ST_IDLE;
                end else if (req_valid) begin
                    issue = CMD_ACT; accept = 1'b1; ld = 1'b1;
                    ldv = TW'(gap_load(T_RCD));
                    nx_state = ST_WAIT; nx_after = req_write ? ST_WR : ST_RD;
                end
            end
            ST_RD, ST_WR: begin
                issue = (state == ST_RD) ? CMD_RD : CMD_WR; ld = 1'b1;
                ldv = TW'(gap_load(T_RECOVER));
                nx_state = ST_WAIT; nx_after = ST_IDLE;
            end
            default: nx_state = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT;
            after_q   <= ST_PRE;
            cmd_q     <= CMD_NOP;
            cke_q     <= 1'b0;
            oe_q      <= 1'b0;
            init_done <= 1'b0;
            a_q       <= '0;
            ba_q      <= '0;
            bank_q    <= '0;
            col_q     <= '0;
            wdata_q   <= '0;
            rdsh      <= '0;
            rdv_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            state   <= nx_state;
            after_q <= nx_after;
            cmd_q   <= issue;
            cke_q   <= 1'b1;
            oe_q    <= (issue == CMD_WR);
            rdsh    <= {rdsh[CAS_LAT-1:0], issue == CMD_RD};
            rdv_q   <= rdsh[CAS_LAT];
            if (rdsh[CAS_LAT]) rdata_q <= sd_dq;
            if (state == ST_LMR) init_done <= 1'b1;
            unique case (issue)
                CMD_PRE: begin a_q <= AP_MASK; ba_q <= '0; end
                CMD_LMR: begin a_q <= MODE_WORD; ba_q <= '0; end
                CMD_ACT: begin
                    a_q     <= req_addr[COL_W+BANK_W +: ROW_W];
                    ba_q    <= req_addr[COL_W +: BANK_W];
                    bank_q  <= req_addr[COL_W +: BANK_W];
                    col_q   <= req_addr[COL_W-1:0];
                    wdata_q <= req_wdata;
                end
                CMD_RD, CMD_WR: begin
                    a_q  <= ROW_W'(col_q) | AP_MASK;
                    ba_q <= bank_q;
                end
                default: ;
            endcase
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_cke   = cke_q;
    assign sd_ba    = ba_q;
    assign sd_a     = a_q;
    assign sd_dq    = oe_q ? wdata_q : 'z;
    assign rd_valid = rdv_q;
    assign rd_data  = rdata_q;

    // R1
    cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> (cmd_q == CMD_NOP));

    // R9
    accept_then_act_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> (cmd_q == CMD_ACT));

    // R5
    act_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

    // R6
    drive_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        oe_q |-> (cmd_q == CMD_WR));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R2
    ready_after_init_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> init_done);

endmodule

// File: tb/sdctl_top_bench.sv
module sdctl_top_bench;
    localparam int CL = 2, INIT = 2700, RINT = 210;
    localparam int TRP = 2, TRC = 2, TRCD = 2, TMRD = 2, TREC = 4;
    localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
        C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic ready, rd_valid, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [31:0] rd_data;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;
    wire  [31:0] sd_dq;

    int checks = 0, failures = 0;

    sdctl_top #(.CAS_LAT(CL), .INIT_CYC(INIT), .REF_INT(RINT), .T_RP(TRP),
                .T_RC(TRC), .T_RCD(TRCD), .T_MRD(TMRD), .T_RECOVER(TREC)) u_sdctl_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq(sd_dq));

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model, sampled on falling edges ----------------
    logic [31:0] mem [logic [23:0]];
    logic [CL:0]  pv = '0;
    logic [31:0]  pd [CL+1];
    logic [12:0]  open_row [4];
    logic [3:0]   open_b = '0;
    int ncyc = 0, last_cyc = -1000, rd_seen = 0, n_init = 0, nop_hi = 0;
    logic [3:0] last_cmd = 4'b0111;
    logic [3:0] init_log [4];
    logic [12:0] init_a [4];
    int viol = 0, dq_bad = 0, lat_bad = 0, addr_bad = 0, bad_code = 0;
    int ref_open = 0, ready_early = 0, ref_cnt = 0, max_gap = 0, last_ref = -1;

    assign sd_dq = pv[CL] ? pd[CL] : 'z;

    function automatic int need_gap(input logic [3:0] c);
        case (c)
            C_PRE: return TRP;
            C_REF: return TRC;
            C_LMR: return TMRD;
            C_ACT: return TRCD;
            C_RD, C_WR: return TREC;
            default: return 0;
        endcase
    endfunction

    always @(negedge clk) begin
        logic [3:0] c;
        logic [23:0] key;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        ncyc <= ncyc + 1;
        for (int i = CL; i > 0; i--) begin pv[i] <= pv[i-1]; pd[i] <= pd[i-1]; end
        pv[0] <= 1'b0;
        pd[0] <= '0;
        if (!rst) begin
            if (ready && n_init < 4) ready_early++;
            if (rd_valid && (ncyc - rd_seen != CL + 1)) lat_bad++;
            if (c == C_WR) begin
                if ($isunknown(sd_dq)) dq_bad++;
            end else if (!pv[CL] && sd_dq !== 32'hzzzz_zzzz) dq_bad++;
            if (c == C_NOP && sd_cke && n_init == 0) nop_hi++;
            if (!(c inside {C_LMR, C_REF, C_PRE, C_ACT, C_WR, C_RD, C_NOP})) bad_code++;
            if (c != C_NOP) begin
                if (ncyc - last_cyc < need_gap(last_cmd)) viol++;
                last_cmd <= c;
                last_cyc <= ncyc;
                if (n_init < 4) begin
                    init_log[n_init] <= c;
                    init_a[n_init]   <= sd_a;
                    n_init <= n_init + 1;
                end
            end
            case (c)
                C_ACT: begin
                    if (open_b[sd_ba]) addr_bad++;
                    open_b[sd_ba] <= 1'b1;
                    open_row[sd_ba] <= sd_a;
                end
                C_RD, C_WR: begin
                    if (!open_b[sd_ba] || !sd_a[10]) addr_bad++;
                    key = {open_row[sd_ba], sd_ba, sd_a[8:0]};
                    open_b[sd_ba] <= 1'b0;
                    if (c == C_WR) mem[key] = sd_dq;
                    else begin
                        pv[0] <= 1'b1;
                        pd[0] <= mem.exists(key) ? mem[key] : 32'hDEAD_BEEF;
                        rd_seen <= ncyc;
                    end
                end
                C_REF: begin
                    if (open_b != '0) ref_open++;
                    if (n_init >= 4) begin
                        ref_cnt++;
                        if (last_ref >= 0 && ncyc - last_ref > max_gap) max_gap = ncyc - last_ref;
                        last_ref <= ncyc;
                    end
                end
                default: ;
            endcase
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit wr, input logic [23:0] ad, input logic [31:0] d,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = ad; req_wdata = d;
        while (!ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (ready) chk(1'b0, "R9 busy after accept", ready, 0);
        if (!wr) begin
            int w = 0;
            while (!rd_valid && w < 50) begin @(negedge clk); w++; end
            chk(rd_valid && rd_data == exp, tag, rd_data, exp);
        end
    endtask

    // {write, addr[23:0], data[31:0]}; addr = {row13, bank2, col9}
    localparam logic [56:0] VEC [10] = '{
        {1'b1, 24'h000000, 32'h1111_1111},
        {1'b1, 24'h000A05, 32'h2222_2222},
        {1'b1, 24'hFFFFFF, 32'h3333_3333},
        {1'b1, 24'h000C05, 32'h4444_4444},
        {1'b0, 24'h000A05, 32'h2222_2222},
        {1'b0, 24'hFFFFFF, 32'h3333_3333},
        {1'b0, 24'h000C05, 32'h4444_4444},
        {1'b1, 24'h000000, 32'hA5A5_A5A5},
        {1'b0, 24'h000000, 32'hA5A5_A5A5},
        {1'b0, 24'h000A05, 32'h2222_2222}
    };

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!sd_cke && {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 cke/nop in reset",
            {sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {1'b0, C_NOP});
        chk(!ready && !rd_valid && sd_dq === 32'hzzzz_zzzz, "R1 ready/rd_valid/dq in reset",
            {ready, rd_valid}, 0);
        rst = 1'b0;
        // R2 bring-up
        while (n_init < 4) @(negedge clk);
        repeat (TMRD + 2) @(negedge clk);
        chk(nop_hi >= INIT, "R2 power-up NOP cycles", nop_hi, INIT);
        chk(init_log[0] == C_PRE && init_a[0][10], "R2 precharge all", {init_log[0], init_a[0]}, {C_PRE, 13'h400});
        chk(init_log[1] == C_REF && init_log[2] == C_REF, "R2 two refreshes", {init_log[1], init_log[2]}, {C_REF, C_REF});
        chk(init_log[3] == C_LMR && init_a[3] == 13'(CL << 4), "R2 mode load", {init_log[3], init_a[3]}, {C_LMR, 13'(CL << 4)});
        chk(ready_early == 0, "R2 ready during bring-up", ready_early, 0);
        chk(ready, "R9 ready after bring-up", ready, 1);
        // R4 R7 vector table
        for (int i = 0; i < 10; i++)
            access(VEC[i][56], VEC[i][55:32], VEC[i][31:0], VEC[i][31:0], "R4 R7 table read");
        // R8 idle refresh
        begin
            int r0 = ref_cnt;
            repeat (3 * RINT + 20) @(negedge clk);
            chk(ref_cnt - r0 >= 3, "R8 idle refreshes", ref_cnt - r0, 3);
        end
        // R8 R9 continuous stream across refresh deadlines
        for (int i = 0; i < 60; i++)
            access(1'b0, i[0] ? 24'hFFFFFF : 24'h000A05, '0,
                   i[0] ? 32'h3333_3333 : 32'h2222_2222, "R7 stream read");
        repeat (20) @(negedge clk);
        chk(max_gap <= RINT + 1 + TRCD + TREC && max_gap > 0, "R8 refresh interval", max_gap, RINT + 1 + TRCD + TREC);
        chk(ref_open == 0, "R8 refresh with open row", ref_open, 0);
        chk(viol == 0, "R5 command spacing", viol, 0);
        chk(dq_bad == 0, "R6 data bus ownership", dq_bad, 0);
        chk(lat_bad == 0, "R7 read latency", lat_bad, 0);
        chk(addr_bad == 0, "R4 row/column/A10", addr_bad, 0);
        chk(bad_code == 0, "R3 command codes", bad_code, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule